// File: doc/BRIEF.md
# Single-Precision Rounding Unit

This block takes an unrounded single-precision value and returns it rounded to 24 significand bits. The value arrives as a sign, an 8-bit biased exponent and a 27-bit wide significand: the upper 24 bits hold the hidden one and the 23-bit fraction, and the lower three hold the extra guard, round and sticky positions. An alignment stage first shifts this wide significand right by a 5-bit amount. Any 1 bit that leaves the low end of the word is folded into the sticky position. The aligned value is then rounded in one of four selectable modes.

When rounding carries out of the 24-bit significand, the significand is renormalised and the exponent is bumped. The unit also reports whether precision was lost and whether the exponent reached the all-ones value. The result is registered: one cycle after an accepted input, `out_valid` rises together with the rounded fields.

Top module: `fp_round_unit`

## Requirements
- R1: With `rnd_mode` = 01 (toward zero), the output significand equals the 24 kept bits after alignment, and the exponent is unchanged.
- R2: With `rnd_mode` = 00 (nearest even), the kept significand is incremented only when guard is 1 and at least one of round, sticky or the kept least significant bit is 1.
- R3: In nearest-even mode, an exact tie (guard, round, sticky = 1, 0, 0) always leaves the least significant output bit at 0.
- R4: With `rnd_mode` = 10 (toward plus infinity), the magnitude is incremented only when the sign is 0 and any of guard, round or sticky is 1.
- R5: With `rnd_mode` = 11 (toward minus infinity), the magnitude is incremented only when the sign is 1 and any of guard, round or sticky is 1.
- R6: If the increment carries out of bit 23, the output significand is 0x800000 and the exponent is the input exponent plus one.
- R7: `exp_ovf` is 1 exactly when a carry-out raises the exponent to 255.
- R8: `inexact` is 1 whenever any of the aligned guard, round or sticky bits is 1, in every mode, and 0 otherwise.
- R9: Alignment shifts the 27-bit word (significand in bits 26..3, guard in bit 2, round in bit 1, sticky in bit 0) right by `shamt`. The new sticky is the OR of the shifted bit 0 and every bit shifted out below it.
- R10: A shift amount of 26 to 31 leaves zero kept bits, zero guard and zero round, and a sticky equal to the OR of the whole input word.
- R11: Reset clears every output to 0. An input with `in_valid` high appears on the outputs one cycle later with `out_valid` high. A cycle with `in_valid` low lowers `out_valid` and holds the result fields.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input fields are valid this cycle |
| rnd_mode | input | 2 | 00 nearest even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| sign_in | input | 1 | Sign of the value |
| exp_in | input | 8 | Biased exponent, at most 254 |
| sig_wide | input | 27 | Significand (26..3), guard (2), round (1), sticky (0) |
| shamt | input | 5 | Right alignment shift amount |
| out_valid | output | 1 | Result valid |
| res_sign | output | 1 | Sign of the result |
| res_exp | output | 8 | Adjusted exponent |
| res_sig | output | 24 | Rounded significand |
| inexact | output | 1 | Precision was lost |
| exp_ovf | output | 1 | Exponent reached 255 through rounding |

## Verification
The assertions assume that the exponent presented with a valid input never exceeds 254. They also assume that the mode, sign and shift inputs are settled values whenever reset is released, so that a captured cycle can be related to its inputs through one `$past`. The stimulus drives every input on the falling edge, keeps `in_valid` low while reset is held, and uses 254 as its largest exponent, reaching 255 only through a rounding carry.

// File: rtl/fpr_pkg.sv
// Package: shared widths and rounding-mode encoding for the rounding unit.
// Assumes single-precision layout: 24-bit significand with hidden one, 8-bit exponent.
package fpr_pkg;

    localparam int SIG_W   = 24;
    localparam int EXP_W   = 8;
    localparam int EXTRA_W = 3;
    localparam int SH_W    = 5;

    typedef enum logic [1:0] {
        RM_NEAR_EVEN = 2'b00,
        RM_TO_ZERO   = 2'b01,
        RM_TO_POS    = 2'b10,
        RM_TO_NEG    = 2'b11
    } rmode_e;

endpackage

// File: rtl/fpr_align_shift.sv
// Module: right-shift aligner that builds kept bits plus guard, round and sticky.
// Input word: significand in the top SIG_W bits, then guard, round, sticky.
// Every 1 that leaves the low end of the word is ORed into sticky.
// Assumes EXTRA_W is 3.
module fpr_align_shift #(
    parameter int SIG_W   = 24,
    parameter int EXTRA_W = 3,
    parameter int SH_W    = 5
) (
    input  logic [SIG_W+EXTRA_W-1:0] src,
    input  logic [SH_W-1:0]          shamt,
    output logic [SIG_W-1:0]         kept,
    output logic                     guard,
    output logic                     round,
    output logic                     sticky
);
    localparam int W = SIG_W + EXTRA_W;

    logic [W-1:0] shifted;
    logic [W-1:0] lost_bits;
    logic [31:0]  shamt_ext;

    assign shamt_ext = {{(32-SH_W){1'b0}}, shamt};
    assign shifted   = src >> shamt;

    // Mark each source bit that falls below bit 0 for the current shift amount.
    for (genvar i = 0; i < W; i++) begin : g_lost
        assign lost_bits[i] = src[i] && (shamt_ext > 32'(i));
    end

    assign kept   = shifted[W-1 -: SIG_W];
    assign guard  = shifted[EXTRA_W-1];
    assign round  = shifted[EXTRA_W-2];
    assign sticky = shifted[0] | (|lost_bits);

endmodule

// File: rtl/fpr_round_decide.sv
// Module: decides whether the kept significand is incremented, and flags inexact.
// Pure combinational; mode encoding comes from fpr_pkg.
module fpr_round_decide
    import fpr_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       sign,
    input  logic       lsb,
    input  logic       guard,
    input  logic       round,
    input  logic       sticky,
    output logic       incr,
    output logic       inexact
);
    logic any_extra;

    assign any_extra = guard | round | sticky;
    assign inexact   = any_extra;

    // Select the increment rule for the active rounding mode.
    always_comb begin
        unique case (rmode_e'(mode))
            RM_NEAR_EVEN: incr = guard & (round | sticky | lsb);
            RM_TO_ZERO:   incr = 1'b0;
            RM_TO_POS:    incr = ~sign & any_extra;
            RM_TO_NEG:    incr = sign & any_extra;
            default:      incr = 1'b0;
        endcase
    end

endmodule

// File: rtl/fpr_incr_norm.sv
// Module: adds the rounding increment and renormalises on carry-out.
// Assumes the incoming exponent is at most all-ones minus one.
module fpr_incr_norm #(
    parameter int SIG_W = 24,
    parameter int EXP_W = 8
) (
    input  logic [SIG_W-1:0] sig_in,
    input  logic [EXP_W-1:0] exp_in,
    input  logic             incr,
    output logic [SIG_W-1:0] sig_out,
    output logic [EXP_W-1:0] exp_out,
    output logic             ovf
);
    logic [SIG_W:0] sum;
    logic           carry;

    assign sum     = {1'b0, sig_in} + (SIG_W+1)'(incr);
    assign carry   = sum[SIG_W];
    assign sig_out = carry ? sum[SIG_W:1] : sum[SIG_W-1:0];
    assign exp_out = exp_in + EXP_W'(carry);
    assign ovf     = carry && (exp_out == {EXP_W{1'b1}});

endmodule

// File: rtl/fp_round_unit.sv
// Module: single-precision rounding unit, top level.
// Aligns the wide significand, rounds in one of four modes, and registers the
// result one cycle after an accepted input. Synchronous active-low reset.
module fp_round_unit
    import fpr_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [1:0]               rnd_mode,
    input  logic                     sign_in,
    input  logic [EXP_W-1:0]         exp_in,
    input  logic [SIG_W+EXTRA_W-1:0] sig_wide,
    input  logic [SH_W-1:0]          shamt,
    output logic                     out_valid,
    output logic                     res_sign,
    output logic [EXP_W-1:0]         res_exp,
    output logic [SIG_W-1:0]         res_sig,
    output logic                     inexact,
    output logic                     exp_ovf
);
    logic [SIG_W-1:0] al_sig;
    logic [2:0]       al_grs;
    logic             rd_incr;
    logic             rd_inexact;
    logic [SIG_W-1:0] n_sig;
    logic [EXP_W-1:0] n_exp;
    logic             n_ovf;

    fpr_align_shift #(
        .SIG_W   (SIG_W),
        .EXTRA_W (EXTRA_W),
        .SH_W    (SH_W)
    ) u_align (
        .src    (sig_wide),
        .shamt  (shamt),
        .kept   (al_sig),
        .guard  (al_grs[2]),
        .round  (al_grs[1]),
        .sticky (al_grs[0])
    );

    fpr_round_decide u_decide (
        .mode    (rnd_mode),
        .sign    (sign_in),
        .lsb     (al_sig[0]),
        .guard   (al_grs[2]),
        .round   (al_grs[1]),
        .sticky  (al_grs[0]),
        .incr    (rd_incr),
        .inexact (rd_inexact)
    );

    fpr_incr_norm #(
        .SIG_W (SIG_W),
        .EXP_W (EXP_W)
    ) u_incr (
        .sig_in  (al_sig),
        .exp_in  (exp_in),
        .incr    (rd_incr),
        .sig_out (n_sig),
        .exp_out (n_exp),
        .ovf     (n_ovf)
    );

    // Output register: capture the rounded result when the input is valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            res_sign  <= 1'b0;
            res_exp   <= '0;
            res_sig   <= '0;
            inexact   <= 1'b0;
            exp_ovf   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                res_sign <= sign_in;
                res_exp  <= n_exp;
                res_sig  <= n_sig;
                inexact  <= rd_inexact;
                exp_ovf  <= n_ovf;
            end
        end
    end

endmodule

// File: rtl/fpr_checker.sv
// Module: property checker for fp_round_unit, attached by bind.
// Assumes exp_in never exceeds 254 on a valid input.
module fpr_checker #(
    parameter int SIG_W = 24,
    parameter int EXP_W = 8,
    parameter int SH_W  = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [1:0]       rnd_mode,
    input logic             sign_in,
    input logic [EXP_W-1:0] exp_in,
    input logic [SH_W-1:0]  shamt,
    input logic [SIG_W-1:0] al_sig,
    input logic [2:0]       al_grs,
    input logic             out_valid,
    input logic [EXP_W-1:0] res_exp,
    input logic [SIG_W-1:0] res_sig,
    input logic             inexact,
    input logic             exp_ovf
);
    localparam logic [SIG_W-1:0] SIG_CARRY = {1'b1, {(SIG_W-1){1'b0}}};

    assert_valid_lat_R11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));

    assert_trunc_keep_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(rnd_mode) == 2'b01)
        |-> (res_sig == $past(al_sig) && res_exp == $past(exp_in)));

    assert_tie_even_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(rnd_mode) == 2'b00 && $past(al_grs) == 3'b100)
        |-> !res_sig[0]);

    assert_pos_neg_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(rnd_mode) == 2'b10 && $past(sign_in))
        |-> res_sig == $past(al_sig));

    assert_neg_pos_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(rnd_mode) == 2'b11 && !$past(sign_in))
        |-> res_sig == $past(al_sig));

    assert_carry_norm_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && res_exp != $past(exp_in)) |-> res_sig == SIG_CARRY);

    assert_ovf_exp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        exp_ovf |-> res_exp == {EXP_W{1'b1}});

    assert_inexact_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> inexact == (|$past(al_grs)));

    assert_far_shift_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (shamt >= SH_W'(26)) |-> (al_sig == '0 && al_grs[2:1] == 2'b00));

endmodule

bind fp_round_unit fpr_checker #(
    .SIG_W (fpr_pkg::SIG_W),
    .EXP_W (fpr_pkg::EXP_W),
    .SH_W  (fpr_pkg::SH_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .rnd_mode  (rnd_mode),
    .sign_in   (sign_in),
    .exp_in    (exp_in),
    .shamt     (shamt),
    .al_sig    (al_sig),
    .al_grs    (al_grs),
    .out_valid (out_valid),
    .res_exp   (res_exp),
    .res_sig   (res_sig),
    .inexact   (inexact),
    .exp_ovf   (exp_ovf)
);

// File: tb/tb_fp_round_unit.sv
// Bench: vector table walked by one loop, then directed reset and hold tests.
module tb_fp_round_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [1:0]  rnd_mode;
    logic        sign_in;
    logic [7:0]  exp_in;
    logic [26:0] sig_wide;
    logic [4:0]  shamt;
    logic        out_valid;
    logic        res_sign;
    logic [7:0]  res_exp;
    logic [23:0] res_sig;
    logic        inexact;
    logic        exp_ovf;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    fp_round_unit dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .rnd_mode  (rnd_mode),
        .sign_in   (sign_in),
        .exp_in    (exp_in),
        .sig_wide  (sig_wide),
        .shamt     (shamt),
        .out_valid (out_valid),
        .res_sign  (res_sign),
        .res_exp   (res_exp),
        .res_sig   (res_sig),
        .inexact   (inexact),
        .exp_ovf   (exp_ovf)
    );

    typedef struct packed {
        logic [1:0]  mode;
        logic        sgn;
        logic [7:0]  ex;
        logic [26:0] wide;
        logic [4:0]  sh;
        logic [23:0] esig;
        logic [7:0]  eexp;
        logic        einx;
        logic        eovf;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{2'b00, 1'b0, 8'h80, {24'h800000, 3'b101}, 5'd0,  24'h800001, 8'h80, 1'b1, 1'b0}, // R2 g&s
        '{2'b00, 1'b0, 8'h80, {24'h800000, 3'b100}, 5'd0,  24'h800000, 8'h80, 1'b1, 1'b0}, // R3 tie even
        '{2'b00, 1'b0, 8'h80, {24'h800001, 3'b100}, 5'd0,  24'h800002, 8'h80, 1'b1, 1'b0}, // R3 tie odd
        '{2'b00, 1'b0, 8'h80, {24'h800001, 3'b011}, 5'd0,  24'h800001, 8'h80, 1'b1, 1'b0}, // R2 no guard
        '{2'b01, 1'b0, 8'h80, {24'hABCDEF, 3'b111}, 5'd0,  24'hABCDEF, 8'h80, 1'b1, 1'b0}, // R1
        '{2'b10, 1'b0, 8'h80, {24'h800000, 3'b001}, 5'd0,  24'h800001, 8'h80, 1'b1, 1'b0}, // R4 pos
        '{2'b10, 1'b1, 8'h80, {24'h800000, 3'b111}, 5'd0,  24'h800000, 8'h80, 1'b1, 1'b0}, // R4 neg
        '{2'b11, 1'b1, 8'h80, {24'h800000, 3'b010}, 5'd0,  24'h800001, 8'h80, 1'b1, 1'b0}, // R5 neg
        '{2'b11, 1'b0, 8'h80, {24'h800000, 3'b111}, 5'd0,  24'h800000, 8'h80, 1'b1, 1'b0}, // R5 pos
        '{2'b00, 1'b0, 8'h80, {24'h800000, 3'b000}, 5'd0,  24'h800000, 8'h80, 1'b0, 1'b0}, // R8 exact
        '{2'b00, 1'b0, 8'h80, {24'hFFFFFF, 3'b110}, 5'd0,  24'h800000, 8'h81, 1'b1, 1'b0}, // R6 carry
        '{2'b10, 1'b0, 8'hFE, {24'hFFFFFF, 3'b001}, 5'd0,  24'h800000, 8'hFF, 1'b1, 1'b1}, // R7 ovf
        '{2'b01, 1'b0, 8'h80, {24'h800000, 3'b000}, 5'd1,  24'h400000, 8'h80, 1'b0, 1'b0}, // R9 shift 1
        '{2'b01, 1'b0, 8'h80, {24'h800003, 3'b000}, 5'd2,  24'h200000, 8'h80, 1'b1, 1'b0}, // R9 g,r
        '{2'b10, 1'b0, 8'h80, {24'h800001, 3'b000}, 5'd4,  24'h080001, 8'h80, 1'b1, 1'b0}, // R9 sticky
        '{2'b00, 1'b0, 8'h80, {24'h800000, 3'b000}, 5'd25, 24'h000000, 8'h80, 1'b1, 1'b0}, // R9 round only
        '{2'b10, 1'b0, 8'h80, {24'h800000, 3'b000}, 5'd26, 24'h000001, 8'h80, 1'b1, 1'b0}, // R10 26
        '{2'b11, 1'b1, 8'h80, {24'hFFFFFF, 3'b111}, 5'd31, 24'h000001, 8'h80, 1'b1, 1'b0}, // R10 31
        '{2'b10, 1'b0, 8'h80, 27'd0,                5'd31, 24'h000000, 8'h80, 1'b0, 1'b0}  // R10 zero
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic v, input vec_t t);
        @(negedge clk);
        in_valid = v;
        rnd_mode = t.mode;
        sign_in  = t.sgn;
        exp_in   = t.ex;
        sig_wide = t.wide;
        shamt    = t.sh;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n    = 1'b0;
        in_valid = 1'b0;
        rnd_mode = 2'b00;
        sign_in  = 1'b0;
        exp_in   = 8'h00;
        sig_wide = '0;
        shamt    = '0;
        repeat (3) @(posedge clk);
        #1;
        // R11: reset state
        check("R11 reset out_valid", 32'(out_valid), 32'd0);
        check("R11 reset res_sig", 32'(res_sig), 32'd0);
        check("R11 reset flags", {30'd0, inexact, exp_ovf}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(1'b1, VECS[i]);
            check($sformatf("vec%0d valid R11", i), 32'(out_valid), 32'd1);
            check($sformatf("vec%0d sig", i), 32'(res_sig), 32'(VECS[i].esig));
            check($sformatf("vec%0d exp", i), 32'(res_exp), 32'(VECS[i].eexp));
            check($sformatf("vec%0d inexact R8", i), 32'(inexact), 32'(VECS[i].einx));
            check($sformatf("vec%0d ovf R7", i), 32'(exp_ovf), 32'(VECS[i].eovf));
            check($sformatf("vec%0d sign", i), 32'(res_sign), 32'(VECS[i].sgn));
        end

        // R11: idle cycle holds the last result and drops out_valid
        drive(1'b0, VECS[0]);
        check("R11 idle out_valid", 32'(out_valid), 32'd0);
        check("R11 idle hold sig", 32'(res_sig), 32'(VECS[NV-1].esig));

        // R1: truncation of a negative value with all extra bits set
        drive(1'b1, '{2'b01, 1'b1, 8'h10, {24'hC00001, 3'b111}, 5'd0, 24'h0, 8'h0, 1'b0, 1'b0});
        check("R1 trunc neg sig", 32'(res_sig), 32'hC00001);
        check("R1 trunc neg exp", 32'(res_exp), 32'h10);

        // R11: mid-stream reset clears outputs
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        @(posedge clk);
        #1;
        check("R11 rereset valid", 32'(out_valid), 32'd0);
        check("R11 rereset sig", 32'(res_sig), 32'd0);
        check("R11 rereset exp", 32'(res_exp), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule